// File: doc/BRIEF.md
# Two-Channel Region Copy Engine

This block moves one contiguous region of 32-bit words between the active memory space and the checkpoint memory space. A save copies active data into checkpoint storage; a restore copies it back. Software loads a source byte base, a destination byte base and a direction, then writes the word count. The write of the count launches the copy at once. The engine cuts the region into two back-to-back pieces and hands each piece to its own channel, so that both halves move at the same time.

Each channel has a read request port, a read response port and a write port. It stages read data in a 16-word buffer and can retire one word per cycle on its write port. The read and write request ports are valid/ready: a request is presented with valid, and it stays unchanged until the cycle in which ready is high. The read response port has no ready. Responses return in request order. A channel never has more words requested or buffered than its buffer holds, so it can always take a response. Three plain status pins give the combined result: busy, done and error.

Top module: `dual_copy_engine`

## Requirements
- R1: With cfg_we high, cfg_addr selects a register: 0 for the source byte base, 1 for the destination byte base, 2 for the direction (bit 0), and 3 for the word count. A count write made while idle starts the transfer, and stat_busy is high from the next cycle. Out of reset, busy, done and error are low and no request is valid.
- R2: For a count N, channel 0 moves ceil(N/2) words starting at the programmed bases. Channel 1 moves floor(N/2) words starting at both bases plus 4*ceil(N/2) bytes.
- R3: Each channel reads word addresses in ascending steps of 4. Destination word k of the region receives source word k, and no word outside the region is written.
- R4: The space tag is 0 for active memory and 1 for checkpoint memory. Direction 0 (save) reads space 0 and writes space 1. Direction 1 (restore) reads space 1 and writes space 0.
- R5: With its write port stalled, a channel issues exactly 16 reads and then waits. It resumes when writes drain the buffer, and the data still arrives intact.
- R6: stat_done rises only when both channels have completed without error. stat_busy stays high until neither channel is active. stat_done and stat_busy are never high together.
- R7: A read response with rd_rsp_err, or a write handshake with wr_err, sets stat_err and stops that channel: it issues no further requests and leaves the failing word unwritten. The other channel runs to its end, and stat_done stays low.
- R8: A zero count sets stat_done in the next cycle. stat_busy does not rise and there is no traffic on any port.
- R9: Register writes, including a count write, are ignored while stat_busy is high. The held bases and direction are used by later transfers.
- R10: stat_done and stat_err are low in the cycle after a transfer starts.
- R11: A read or write request that is valid and not accepted stays valid with the same address and data in the next cycle.
- R12: With both ports always ready and one-cycle read latency, a 32-word transfer finishes within 24 cycles of its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 source, 1 destination, 2 direction, 3 count/start |
| cfg_wdata | input | 32 | Register write data |
| stat_busy | output | 1 | A channel is active |
| stat_done | output | 1 | Both channels completed cleanly |
| stat_err | output | 1 | A channel hit a bus error |
| rd_req_valid | output | 2 | Read request valid, one bit per channel |
| rd_req_ready | input | 2 | Read request accepted |
| rd_req_addr | output | 2x32 | Read byte address per channel |
| rd_req_space | output | 2 | Read space tag (0 active, 1 checkpoint) |
| rd_rsp_valid | input | 2 | Read data returned |
| rd_rsp_data | input | 2x32 | Read data per channel |
| rd_rsp_err | input | 2 | Returned read carries a bus error |
| wr_valid | output | 2 | Write request valid |
| wr_ready | input | 2 | Write request accepted |
| wr_addr | output | 2x32 | Write byte address per channel |
| wr_data | output | 2x32 | Write data per channel |
| wr_space | output | 2 | Write space tag |
| wr_err | input | 2 | Bus error on the accepted write |

## Verification
The bench uses odd counts, a count of one and a count of zero. An engine that rounded the halves the wrong way, or placed channel 1 at the wrong offset, would leave a gap or write one word twice. An engine that ignored a zero count would hang busy. The bench stalls the write port to show that the read-ahead stops at exactly the buffer depth; an off-by-one credit count would overrun the buffer or stall one word early. It injects read and write errors into one channel and checks two things: the other channel still finishes, and the failing word is never written. It also writes to the registers mid-transfer and confirms that the copy and the held settings are unchanged, which a design that latched those writes or restarted on them would fail.

// File: rtl/cpy_pkg.sv
package cpy_pkg;
  localparam int NCH = 2;

  localparam logic [1:0] CFG_SRC = 2'd0;
  localparam logic [1:0] CFG_DST = 2'd1;
  localparam logic [1:0] CFG_DIR = 2'd2;
  localparam logic [1:0] CFG_LEN = 2'd3;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2
  } ch_state_e;
endpackage

// File: rtl/cpy_fifo.sv
module cpy_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign dout  = store[rptr];
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/cpy_split.sv
module cpy_split
  import cpy_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [LW-1:0]           total,
  input  logic [AW-1:0]           src,
  input  logic [AW-1:0]           dst,
  output logic [NCH-1:0][LW-1:0]  part_len,
  output logic [NCH-1:0][AW-1:0]  part_src,
  output logic [NCH-1:0][AW-1:0]  part_dst
);
  logic [LW-1:0] first_len;
  logic [AW-1:0] byte_off;

  always_comb begin
    first_len   = (total >> 1) + LW'(total[0]);
    byte_off    = AW'(first_len) << 2;
    part_len[0] = first_len;
    part_len[1] = total >> 1;
    part_src[0] = src;
    part_dst[0] = dst;
    part_src[1] = src + byte_off;
    part_dst[1] = dst + byte_off;
  end
endmodule

// File: rtl/cpy_chan.sv
module cpy_chan
  import cpy_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] len,
  input  logic          dir,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          rd_space,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_err,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_space,
  input  logic          wr_err,
  output logic          running,
  output logic          done,
  output logic          err
);
  localparam int PW = $clog2(DEPTH);

  ch_state_e     state;
  logic [LW-1:0] rd_left, wr_left;
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [PW:0]   outst, outst_nxt, fcnt;
  logic [PW+1:0] used;
  logic          dir_q, done_q, err_q;
  logic          rd_fire, wr_fire, bad, fifo_empty, push;

  assign used     = {1'b0, fcnt} + {1'b0, outst};
  assign rd_valid = (state == CH_RUN) && (rd_left != '0) && (used < (PW+2)'(DEPTH));
  assign wr_valid = (state == CH_RUN) && !fifo_empty;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_fire  = wr_valid && wr_ready;
  assign bad      = (state == CH_RUN) && ((rsp_valid && rsp_err) || (wr_fire && wr_err));
  assign push     = (state == CH_RUN) && rsp_valid && !rsp_err;
  assign outst_nxt = outst + (PW+1)'(rd_fire) - (PW+1)'(rsp_valid);

  cpy_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (bad),
    .push  (push),
    .din   (rsp_data),
    .pop   (wr_fire),
    .dout  (wr_data),
    .empty (fifo_empty),
    .count (fcnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CH_IDLE;
      rd_left <= '0;
      wr_left <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      outst   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        CH_IDLE: begin
          if (start) begin
            done_q  <= (len == '0);
            err_q   <= 1'b0;
            dir_q   <= dir;
            rd_ptr  <= src;
            wr_ptr  <= dst;
            rd_left <= len;
            wr_left <= len;
            outst   <= '0;
            if (len != '0) state <= CH_RUN;
          end
        end
        CH_RUN: begin
          outst <= outst_nxt;
          if (rd_fire) begin
            rd_ptr  <= rd_ptr + AW'(4);
            rd_left <= rd_left - 1'b1;
          end
          if (wr_fire) begin
            wr_ptr  <= wr_ptr + AW'(4);
            wr_left <= wr_left - 1'b1;
          end
          if (bad) begin
            err_q <= 1'b1;
            state <= (outst_nxt != '0) ? CH_DRAIN : CH_IDLE;
          end else if (wr_fire && wr_left == LW'(1)) begin
            done_q <= 1'b1;
            state  <= CH_IDLE;
          end
        end
        CH_DRAIN: begin
          outst <= outst - (PW+1)'(rsp_valid);
          if (rsp_valid && outst == (PW+1)'(1)) state <= CH_IDLE;
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  assign rd_addr  = rd_ptr;
  assign wr_addr  = wr_ptr;
  assign rd_space = dir_q;
  assign wr_space = ~dir_q;
  assign running  = (state != CH_IDLE);
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/dual_copy_engine.sv
module dual_copy_engine
  import cpy_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic                     stat_busy,
  output logic                     stat_done,
  output logic                     stat_err,
  output logic [1:0]               rd_req_valid,
  input  logic [1:0]               rd_req_ready,
  output logic [1:0][AW-1:0]       rd_req_addr,
  output logic [1:0]               rd_req_space,
  input  logic [1:0]               rd_rsp_valid,
  input  logic [1:0][DW-1:0]       rd_rsp_data,
  input  logic [1:0]               rd_rsp_err,
  output logic [1:0]               wr_valid,
  input  logic [1:0]               wr_ready,
  output logic [1:0][AW-1:0]       wr_addr,
  output logic [1:0][DW-1:0]       wr_data,
  output logic [1:0]               wr_space,
  input  logic [1:0]               wr_err
);
  logic [AW-1:0]          src_q, dst_q;
  logic                   dir_q;
  logic                   start;
  logic [NCH-1:0]         ch_run, ch_done, ch_err;
  logic [NCH-1:0][LW-1:0] p_len;
  logic [NCH-1:0][AW-1:0] p_src, p_dst;

  assign stat_busy = |ch_run;
  assign start     = cfg_we && (cfg_addr == CFG_LEN) && !stat_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      dir_q <= 1'b0;
    end else if (cfg_we && !stat_busy) begin
      case (cfg_addr)
        CFG_SRC: src_q <= AW'(cfg_wdata);
        CFG_DST: dst_q <= AW'(cfg_wdata);
        CFG_DIR: dir_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  cpy_split #(.AW(AW), .LW(LW)) u_split (
    .total    (cfg_wdata[LW-1:0]),
    .src      (src_q),
    .dst      (dst_q),
    .part_len (p_len),
    .part_src (p_src),
    .part_dst (p_dst)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cpy_chan #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(DEPTH)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .src       (p_src[g]),
      .dst       (p_dst[g]),
      .len       (p_len[g]),
      .dir       (dir_q),
      .rd_valid  (rd_req_valid[g]),
      .rd_ready  (rd_req_ready[g]),
      .rd_addr   (rd_req_addr[g]),
      .rd_space  (rd_req_space[g]),
      .rsp_valid (rd_rsp_valid[g]),
      .rsp_data  (rd_rsp_data[g]),
      .rsp_err   (rd_rsp_err[g]),
      .wr_valid  (wr_valid[g]),
      .wr_ready  (wr_ready[g]),
      .wr_addr   (wr_addr[g]),
      .wr_data   (wr_data[g]),
      .wr_space  (wr_space[g]),
      .wr_err    (wr_err[g]),
      .running   (ch_run[g]),
      .done      (ch_done[g]),
      .err       (ch_err[g])
    );
  end

  assign stat_done = &ch_done;
  assign stat_err  = |ch_err;
endmodule

// File: rtl/cpy_chk.sv
module cpy_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [1:0]           cfg_addr,
  input logic                 stat_busy,
  input logic                 stat_done,
  input logic                 stat_err,
  input logic [1:0]           rd_req_valid,
  input logic [1:0]           rd_req_ready,
  input logic [1:0][AW-1:0]   rd_req_addr,
  input logic [1:0]           rd_req_space,
  input logic [1:0]           wr_valid,
  input logic [1:0]           wr_ready,
  input logic [1:0][AW-1:0]   wr_addr,
  input logic [1:0][DW-1:0]   wr_data,
  input logic [1:0]           wr_space
);
  // R6
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_done && stat_err));

  // R6
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy |-> !stat_done);

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd3 && !stat_busy) |=> (!stat_err && !stat_done) || !stat_busy);

  for (genvar c = 0; c < 2; c++) begin : g_c
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid[c] && !rd_req_ready[c]) |=> (rd_req_valid[c] && $stable(rd_req_addr[c])));

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid[c] && !wr_ready[c]) |=> (wr_valid[c] && $stable(wr_addr[c]) && $stable(wr_data[c])));

    // R4
    space_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid[c] && wr_valid[c]) |-> (rd_req_space[c] != wr_space[c]));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_busy |-> (!rd_req_valid[c] && !wr_valid[c]));
  end
endmodule

bind dual_copy_engine cpy_chk #(.AW(AW), .DW(DW)) u_cpy_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .stat_busy    (stat_busy),
  .stat_done    (stat_done),
  .stat_err     (stat_err),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_req_space (rd_req_space),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_space     (wr_space)
);

// File: tb/test_dual_copy_engine.sv
module test_dual_copy_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_addr = '0;
  logic [31:0]     cfg_wdata = '0;
  logic            stat_busy, stat_done, stat_err;
  logic [1:0]      rd_req_valid, rd_req_space, wr_valid, wr_space;
  logic [1:0]      rrdy = 2'b11, wrdy = 2'b11;
  logic [1:0][31:0] rd_req_addr, wr_addr, wr_data;
  logic [1:0]      rsp_v, rsp_e, wr_err;
  logic [1:0][31:0] rsp_d;

  int total = 0;
  int bad = 0;

  logic        mem_init = 1'b0, clr = 1'b0;
  logic        inj_rd_en = 1'b0, inj_wr_en = 1'b0;
  logic [31:0] inj_rd_addr = '0, inj_wr_addr = '0;
  logic [31:0] mem_a [256];
  logic [31:0] mem_c [256];
  int          rd_cnt [2];
  int          wr_cnt [2];
  logic [31:0] first_rd [2];
  logic [31:0] first_wr [2];

  dual_copy_engine i_dual_copy_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stat_busy(stat_busy), .stat_done(stat_done), .stat_err(stat_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rrdy), .rd_req_addr(rd_req_addr),
    .rd_req_space(rd_req_space), .rd_rsp_valid(rsp_v), .rd_rsp_data(rsp_d), .rd_rsp_err(rsp_e),
    .wr_valid(wr_valid), .wr_ready(wrdy), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_space(wr_space), .wr_err(wr_err)
  );

  always_comb begin
    for (int c = 0; c < 2; c++)
      wr_err[c] = inj_wr_en && wr_valid[c] && (wr_addr[c] == inj_wr_addr);
  end

  // memory model: one-cycle read latency, space 0 = active, 1 = checkpoint
  always @(posedge clk) begin
    if (mem_init) begin
      for (int k = 0; k < 256; k++) begin
        mem_a[k] <= 32'hA000_0000 + k;
        mem_c[k] <= 32'hC000_0000 + k;
      end
    end
    for (int c = 0; c < 2; c++) begin
      rsp_v[c] <= 1'b0;
      rsp_e[c] <= 1'b0;
      if (clr) begin
        rd_cnt[c] <= 0;
        wr_cnt[c] <= 0;
      end
      if (rd_req_valid[c] && rrdy[c]) begin
        rsp_v[c] <= 1'b1;
        rsp_d[c] <= rd_req_space[c] ? mem_c[rd_req_addr[c][9:2]] : mem_a[rd_req_addr[c][9:2]];
        rsp_e[c] <= inj_rd_en && (rd_req_addr[c] == inj_rd_addr);
        if (!clr) rd_cnt[c] <= rd_cnt[c] + 1;
        if (clr || rd_cnt[c] == 0) first_rd[c] <= rd_req_addr[c];
      end
      if (wr_valid[c] && wrdy[c] && !wr_err[c]) begin
        if (wr_space[c]) mem_c[wr_addr[c][9:2]] <= wr_data[c];
        else             mem_a[wr_addr[c][9:2]] <= wr_data[c];
        if (!clr) wr_cnt[c] <= wr_cnt[c] + 1;
        if (clr || wr_cnt[c] == 0) first_wr[c] <= wr_addr[c];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prep();
    @(negedge clk);
    mem_init = 1'b1; clr = 1'b1;
    inj_rd_en = 1'b0; inj_wr_en = 1'b0;
    rrdy = 2'b11; wrdy = 2'b11;
    @(negedge clk);
    mem_init = 1'b0; clr = 1'b0;
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic dir, input logic [31:0] n);
    cfg_write(2'd0, s);
    cfg_write(2'd1, d);
    cfg_write(2'd2, {31'b0, dir});
    cfg_write(2'd3, n);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (stat_busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "transfer finishes", 32'(stat_busy), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", 32'(stat_busy), 0);
    chk("R1", "done after reset", 32'(stat_done), 0);
    chk("R1", "err after reset", 32'(stat_err), 0);
    chk("R1", "no requests after reset", 32'({rd_req_valid, wr_valid}), 0);
  endtask

  task automatic t_save_even();
    prep();
    launch(32'h40, 32'h100, 1'b0, 10);
    chk("R1", "busy after start", 32'(stat_busy), 1);
    wait_idle("R6");
    chk("R6", "done after both", 32'(stat_done), 1);
    chk("R6", "no err", 32'(stat_err), 0);
    chk("R2", "ch0 reads", rd_cnt[0], 5);
    chk("R2", "ch1 reads", rd_cnt[1], 5);
    chk("R2", "ch1 first read", first_rd[1], 32'h54);
    chk("R2", "ch1 first write", first_wr[1], 32'h114);
    for (int k = 0; k < 10; k++)
      chk("R3", "save data", mem_c[64+k], 32'hA000_0000 + 16 + k);
    chk("R3", "word past region", mem_c[74], 32'hC000_0000 + 74);
    chk("R4", "active space untouched", mem_a[64], 32'hA000_0000 + 64);
  endtask

  task automatic t_restore_odd();
    prep();
    launch(32'h200, 32'h80, 1'b1, 7);
    wait_idle("R4");
    chk("R2", "ch0 ceil share", rd_cnt[0], 4);
    chk("R2", "ch1 floor share", rd_cnt[1], 3);
    chk("R2", "ch1 first read odd", first_rd[1], 32'h210);
    chk("R2", "ch1 first write odd", first_wr[1], 32'h90);
    for (int k = 0; k < 7; k++)
      chk("R4", "restore data", mem_a[32+k], 32'hC000_0000 + 128 + k);
    chk("R3", "word past restore", mem_a[39], 32'hA000_0000 + 39);
  endtask

  task automatic t_one();
    prep();
    launch(32'h0, 32'h300, 1'b0, 1);
    wait_idle("R2");
    chk("R2", "single word ch0", rd_cnt[0], 1);
    chk("R2", "single word ch1 idle", rd_cnt[1], 0);
    chk("R2", "single word data", mem_c[192], 32'hA000_0000);
    chk("R6", "single word done", 32'(stat_done), 1);
  endtask

  task automatic t_zero();
    prep();
    launch(32'h0, 32'h300, 1'b0, 0);
    chk("R8", "zero done next cycle", 32'(stat_done), 1);
    chk("R8", "zero not busy", 32'(stat_busy), 0);
    repeat (5) @(negedge clk);
    chk("R8", "zero no reads", 32'(rd_cnt[0] + rd_cnt[1]), 0);
    chk("R8", "zero no writes", 32'(wr_cnt[0] + wr_cnt[1]), 0);
  endtask

  task automatic t_backpressure();
    prep();
    rrdy = 2'b00; wrdy = 2'b00;
    launch(32'h0, 32'h200, 1'b0, 40);
    repeat (5) @(negedge clk);
    chk("R11", "no read accepted while stalled", 32'(rd_cnt[0]), 0);
    rrdy = 2'b11;
    repeat (40) @(negedge clk);
    chk("R5", "ch0 read-ahead limit", rd_cnt[0], 16);
    chk("R5", "ch1 read-ahead limit", rd_cnt[1], 16);
    chk("R6", "not done while stalled", 32'(stat_done), 0);
    wrdy = 2'b11;
    wait_idle("R5");
    chk("R6", "done after drain", 32'(stat_done), 1);
    for (int k = 0; k < 40; k++)
      chk("R5", "stalled copy data", mem_c[128+k], 32'hA000_0000 + k);
  endtask

  task automatic t_busy_writes();
    prep();
    wrdy = 2'b00;
    launch(32'h40, 32'h100, 1'b0, 20);
    cfg_write(2'd0, 32'h3C0);
    cfg_write(2'd1, 32'h3C0);
    cfg_write(2'd2, 32'h1);
    cfg_write(2'd3, 32'd2);
    wrdy = 2'b11;
    wait_idle("R9");
    chk("R9", "ch0 reads unchanged", rd_cnt[0], 10);
    chk("R9", "ch1 reads unchanged", rd_cnt[1], 10);
    for (int k = 0; k < 20; k++)
      chk("R9", "data with ignored writes", mem_c[64+k], 32'hA000_0000 + 16 + k);
    chk("R9", "ignored dst untouched", mem_c[240], 32'hC000_0000 + 240);
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    cfg_write(2'd3, 32'd4);
    wait_idle("R9");
    chk("R9", "held source base", first_rd[0], 32'h40);
    chk("R9", "held dest base", first_wr[0], 32'h100);
    chk("R9", "held direction", mem_c[65], 32'hA000_0000 + 17);
  endtask

  task automatic t_read_err();
    prep();
    inj_rd_en = 1'b1; inj_rd_addr = 32'h48;
    launch(32'h40, 32'h100, 1'b0, 20);
    wait_idle("R7");
    chk("R7", "err set on read error", 32'(stat_err), 1);
    chk("R7", "done low on read error", 32'(stat_done), 0);
    chk("R7", "other channel finished", wr_cnt[1], 10);
    chk("R7", "failing channel stopped", 32'(wr_cnt[0] < 3), 1);
    chk("R7", "failing word unwritten", mem_c[66], 32'hC000_0000 + 66);
  endtask

  task automatic t_clear();
    prep();
    launch(32'h40, 32'h100, 1'b0, 4);
    chk("R10", "err cleared at start", 32'(stat_err), 0);
    chk("R10", "done cleared at start", 32'(stat_done), 0);
    wait_idle("R10");
    chk("R10", "done after clean run", 32'(stat_done), 1);
  endtask

  task automatic t_write_err();
    prep();
    inj_wr_en = 1'b1; inj_wr_addr = 32'h114;
    launch(32'h40, 32'h100, 1'b0, 8);
    wait_idle("R7");
    chk("R7", "err on write error", 32'(stat_err), 1);
    chk("R7", "done low on write error", 32'(stat_done), 0);
    chk("R7", "ch0 completes", wr_cnt[0], 4);
    chk("R7", "word before error written", mem_c[68], 32'hA000_0000 + 20);
    chk("R7", "errored word unwritten", mem_c[69], 32'hC000_0000 + 69);
    chk("R7", "later word unwritten", mem_c[70], 32'hC000_0000 + 70);
  endtask

  task automatic t_speed();
    int cyc = 1;
    prep();
    launch(32'h0, 32'h200, 1'b0, 32);
    while (stat_busy && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12", "32 words within 24 cycles", 32'(cyc <= 24), 1);
    chk("R12", "fast run done", 32'(stat_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_save_even();
    t_restore_odd();
    t_one();
    t_zero();
    t_backpressure();
    t_busy_writes();
    t_read_err();
    t_clear();
    t_write_err();
    t_speed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule